// File: doc/BRIEF.md
# Streaming 32-bit Checksum Accumulator

This block keeps a 32-bit running sum over a stream of 128-bit data words. On every clock edge where the data strobe is high, the incoming word is cut into four 32-bit lanes. Those four lanes and the current running total are added together in a single step. Any carry out of the top bit is thrown away, so the total is always taken modulo 2^32. Because the block can take a new word on every cycle, a long buffer can be streamed through it without gaps.

A separate load strobe starts a new checksum. It loads a caller-supplied starting value. If the load strobe and the data strobe are high in the same cycle, the word is added on top of the starting value rather than on top of the old total. The total is a register, so each update shows on `sum_o` one cycle after the edge that absorbed it. A one-cycle flag on `done_o` marks that output as freshly updated by data.

Internally the five operands are reduced to two vectors by a chain of carry-save stages. One carry-propagate addition then turns those two vectors into the next total. A parameter can replace the whole tree with a plain behavioural sum.

Top module: `csum_accum`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `sum_o` is 0 and `done_o` is 0.
- R2: At a clock edge with `valid_i` high and `init_i` low, the next `sum_o` is the old `sum_o` plus the four 32-bit lanes of `data_i`. The lanes are data_i[127:96], [95:64], [63:32] and [31:0].
- R3: The addition is modulo 2^32: every carry out of bit 31 is discarded, including carries produced by several lanes at once.
- R4: A new word is absorbed on every cycle that `valid_i` is high, with no idle cycle needed between words.
- R5: At an edge with `init_i` high and `valid_i` low, the next `sum_o` equals `init_val_i`.
- R6: At an edge with both `init_i` and `valid_i` high, the next `sum_o` is `init_val_i` plus the four lanes of `data_i`. The old total is not used.
- R7: At an edge with both `init_i` and `valid_i` low, `sum_o` keeps its value, whatever is on `data_i` and `init_val_i`.
- R8: `done_o` is high in exactly those cycles that follow an edge where `valid_i` was high. It stays low after an edge that only loaded a starting value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low synchronous reset |
| init_i | input | 1 | Load strobe: start a new checksum from `init_val_i` |
| init_val_i | input | 32 | Starting value for a new checksum |
| data_i | input | 128 | Data word, four 32-bit lanes |
| valid_i | input | 1 | Data strobe: add `data_i` this cycle |
| sum_o | output | 32 | Running checksum |
| done_o | output | 1 | High for one cycle after each absorbed word |

## Verification
The only state in this block is the total register and the done flag. A wrong total therefore shows up on `sum_o` in the very next cycle, and it stays wrong for every later word until a new starting value is loaded. A dropped carry-save carry, or a lane that is counted twice, makes the value differ from the reference at the first word that exercises that bit. For this reason the stimulus mixes all-ones lanes, single-bit lanes and ordinary values. A wrong choice between the old total and the starting value shows up one cycle after a load strobe. A missed hold shows up one cycle after any idle cycle that carries garbage data.

// File: rtl/csum_pkg.sv
package csum_pkg;
   // Which adder structure forms the next total
   typedef enum logic {
      ADD_CSA  = 1'b0,
      ADD_FLAT = 1'b1
   } adder_e;
endpackage

// File: rtl/csum_csa32.sv
// One 3:2 carry-save stage, width W, with the carry weight dropped past the MSB
module csum_csa32 #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] c_i,
   output logic [W-1:0] s_o,
   output logic [W-1:0] cy_o
);
   logic [W-1:0] maj;

   assign s_o  = a_i ^ b_i ^ c_i;
   assign maj  = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
   assign cy_o = {maj[W-2:0], 1'b0};
endmodule

// File: rtl/csum_csa_tree.sv
// Reduces N operands to a sum/carry pair with a chain of N-2 carry-save stages
module csum_csa_tree #(
   parameter int W = 32,
   parameter int N = 5
) (
   input  logic [W-1:0] ops_i [N],
   output logic [W-1:0] s_o,
   output logic [W-1:0] cy_o
);
   localparam int STAGES = N - 2;

   if (N < 3) begin : g_bad_n
      $error("csum_csa_tree needs at least three operands");
   end

   logic [W-1:0] s_w  [STAGES];
   logic [W-1:0] cy_w [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         csum_csa32 #(.W(W)) csa_i (
            .a_i (ops_i[0]),
            .b_i (ops_i[1]),
            .c_i (ops_i[2]),
            .s_o (s_w[i]),
            .cy_o(cy_w[i])
         );
      end else begin : g_next
         csum_csa32 #(.W(W)) csa_i (
            .a_i (s_w[i-1]),
            .b_i (cy_w[i-1]),
            .c_i (ops_i[i+2]),
            .s_o (s_w[i]),
            .cy_o(cy_w[i])
         );
      end
   end

   assign s_o  = s_w[STAGES-1];
   assign cy_o = cy_w[STAGES-1];
endmodule

// File: rtl/csum_accum.sv
module csum_accum
   import csum_pkg::*;
#(
   parameter int     DATA_W = 128,
   parameter int     SUM_W  = 32,
   parameter adder_e ADDER  = ADD_CSA
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              init_i,
   input  logic [SUM_W-1:0]  init_val_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              valid_i,
   output logic [SUM_W-1:0]  sum_o,
   output logic              done_o
);
   localparam int LANES = DATA_W / SUM_W;
   localparam int OPS   = LANES + 1;

   if (DATA_W % SUM_W != 0) begin : g_bad_width
      $error("DATA_W must be a multiple of SUM_W");
   end
   if (SUM_W < 2) begin : g_bad_sum
      $error("SUM_W must be at least 2");
   end

   logic [SUM_W-1:0] sum_q;
   logic             done_q;
   logic [SUM_W-1:0] base;
   logic [SUM_W-1:0] ops [OPS];
   logic [SUM_W-1:0] nxt_sum;

   // A load strobe replaces the old total as the fifth operand
   assign base = init_i ? init_val_i : sum_q;

   // Lane 0 is the most significant word of the data
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign ops[k] = data_i[DATA_W-1-k*SUM_W -: SUM_W];
   end
   assign ops[LANES] = base;

   if (ADDER == ADD_CSA) begin : g_csa
      logic [SUM_W-1:0] red_s;
      logic [SUM_W-1:0] red_c;
      logic [SUM_W-1:0] flat_ref;

      csum_csa_tree #(.W(SUM_W), .N(OPS)) tree_i (
         .ops_i(ops),
         .s_o  (red_s),
         .cy_o (red_c)
      );
      assign nxt_sum = red_s + red_c;

      always_comb begin
         flat_ref = '0;
         for (int k = 0; k < OPS; k++) flat_ref = flat_ref + ops[k];
      end

      // R3
      tree_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         valid_i |-> (nxt_sum == flat_ref));
   end else begin : g_flat
      always_comb begin
         nxt_sum = '0;
         for (int k = 0; k < OPS; k++) nxt_sum = nxt_sum + ops[k];
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sum_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= valid_i;
         if (valid_i)     sum_q <= nxt_sum;
         else if (init_i) sum_q <= init_val_i;
      end
   end

   assign sum_o  = sum_q;
   assign done_o = done_q;

   // R7
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!valid_i && !init_i) |=> $stable(sum_o));
   // R5
   init_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (init_i && !valid_i) |=> (sum_o == $past(init_val_i)));
   // R8
   done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> done_o);
   // R8
   done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !done_o);
endmodule

// File: tb/csum_accum_tb.sv
module csum_accum_tb_top;
   logic         clk_i = 1'b0;
   logic         rst_ni = 1'b0;
   logic         init_i = 1'b0;
   logic [31:0]  init_val_i = '0;
   logic [127:0] data_i = '0;
   logic         valid_i = 1'b0;
   logic [31:0]  sum_o;
   logic         done_o;

   int n_run = 0;
   int n_fail = 0;
   logic [31:0] model_sum = '0;

   always #2 clk_i = ~clk_i;

   csum_accum dut_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i), .init_val_i(init_val_i),
      .data_i(data_i), .valid_i(valid_i), .sum_o(sum_o), .done_o(done_o)
   );

   // Stimulus table: {init, valid, init_val, data}
   typedef struct packed {
      logic         ini;
      logic         vld;
      logic [31:0]  iv;
      logic [127:0] dat;
   } step_t;

   localparam step_t VEC [10] = '{
      '{1'b1, 1'b0, 32'h1000_0000, 128'h0},
      '{1'b0, 1'b1, 32'h0,         128'h00000001_00000002_00000003_00000004},
      '{1'b0, 1'b1, 32'h0,         128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF},
      '{1'b0, 1'b0, 32'hDEAD_BEEF, 128'h12345678_9ABCDEF0_0F0F0F0F_F0F0F0F0},
      '{1'b0, 1'b1, 32'h0,         128'h80000000_80000000_80000000_80000000},
      '{1'b1, 1'b1, 32'h0000_00FF, 128'h00000100_00000200_00000300_00000400},
      '{1'b0, 1'b1, 32'h0,         128'h00000001_00000000_00000000_00000000},
      '{1'b0, 1'b1, 32'h0,         128'h00000000_00000000_00000000_80000000},
      '{1'b1, 1'b0, 32'hFFFF_FFFF, 128'hFFFFFFFF_00000000_FFFFFFFF_00000000},
      '{1'b0, 1'b1, 32'h0,         128'h00000001_00000000_00000000_00000000}
   };

   function automatic logic [31:0] lanes_sum(input logic [127:0] d);
      return d[127:96] + d[95:64] + d[63:32] + d[31:0];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive at the falling edge, the edge updates the register, check at the next falling edge
   task automatic step(input logic ini, input logic vld, input logic [31:0] iv,
                       input logic [127:0] dat, input string req);
      init_i = ini; valid_i = vld; init_val_i = iv; data_i = dat;
      if (vld)      model_sum = (ini ? iv : model_sum) + lanes_sum(dat);
      else if (ini) model_sum = iv;
      @(negedge clk_i);
      check(req, sum_o, model_sum);
      check({req, " done"}, {31'd0, done_o}, {31'd0, vld});
   endtask

   initial begin : watchdog
      #40000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk_i);
      // R1 reset state, also with strobes active during reset
      init_i = 1'b1; valid_i = 1'b1; init_val_i = 32'h5555_5555; data_i = '1;
      @(negedge clk_i);
      check("R1", sum_o, 32'h0);
      check("R1 done", {31'd0, done_o}, 32'h0);
      init_i = 1'b0; valid_i = 1'b0;
      rst_ni = 1'b1;
      @(negedge clk_i);
      check("R1 after release", sum_o, 32'h0);
      check("R1 done after release", {31'd0, done_o}, 32'h0);

      // Table walk covering R2 R3 R4 R5 R6 R7 R8
      for (int i = 0; i < 10; i++) begin
         step(VEC[i].ini, VEC[i].vld, VEC[i].iv, VEC[i].dat, $sformatf("R2/R3/R5/R6/R7 vec%0d", i));
      end

      // R4 back-to-back burst, one word per cycle
      step(1'b1, 1'b0, 32'h0, '0, "R5 clear");
      for (int i = 0; i < 16; i++) begin
         step(1'b0, 1'b1, 32'h0, {4{32'(i * 32'h0101_0101 + 7)}}, "R4 burst");
      end
      check("R4 burst total", sum_o, model_sum);

      // R7 idle with garbage on every input but the strobes
      for (int i = 0; i < 3; i++) begin
         step(1'b0, 1'b0, 32'hA5A5_0000 + 32'(i), {4{32'hCAFE_F00D}}, "R7 hold");
      end

      // R3 multi-lane wrap from a high base
      step(1'b1, 1'b1, 32'hFFFF_FFFE, {4{32'hC000_0000}}, "R3/R6 wrap");
      // R8 load alone leaves done low
      step(1'b1, 1'b0, 32'h0000_1234, '1, "R5/R8 load only");

      // R1 reset mid-stream
      rst_ni = 1'b0;
      @(negedge clk_i);
      rst_ni = 1'b1;
      model_sum = '0;
      check("R1 mid-run reset", sum_o, 32'h0);
      check("R1 mid-run done", {31'd0, done_o}, 32'h0);
      step(1'b0, 1'b1, 32'h0, 128'h00000010_00000020_00000030_00000040, "R2 after reset");

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule